// File: doc/BRIEF.md
# Register-Operand Execute Stage

This block is the execute stage of a small 16-bit load/store datapath with eight general registers. Each cycle in which the write strobe is high, it reads the operands named by the decoded instruction and runs them through an adder, a logic unit or a barrel shifter. It writes the result to the destination register in the same clock edge and updates the four condition flags: negative, zero, overflow and carry.

Two operand forms are handled. Arithmetic and logic operations use three register indices: destination, first source and second source. Shifts use two indices. The destination is also the value to be shifted, and the second source supplies the shift count. Register 0 is a constant zero. An operation that targets it only updates the flags, which lets software compare values without losing a register.

A separate write path lets the memory stage place loaded data into the register file. That path has lower priority than the ALU. The whole register file is exposed as a flat vector so the rest of the pipeline can observe it.

Top module: `rex_exec`

## Requirements
- R1: While rst_ni is low, every register and all four flags are cleared. They read zero after reset is released until the first write.
- R2: Register 0 always reads zero. An operation with rd_i = 0 leaves every register unchanged but still updates the flags as it would for any other destination.
- R3: When neither we_i nor ext_we_i is high at a rising edge, no register and no flag changes.
- R4: Opcode 0 (add) gives RS1+RS2, opcode 1 (add with carry) gives RS1+RS2+C, and opcode 2 (subtract) gives RS1−RS2. After add and add-with-carry, C is the carry out of bit 15. After subtract, C is the borrow, set when RS1 < RS2 unsigned.
- R5: For opcodes 0 to 2, V is set exactly when the signed result overflows 16 bits. For all other opcodes, V is cleared.
- R6: Opcodes 3, 4 and 5 give RS1 AND RS2, RS1 OR RS2 and RS1 XOR RS2. They clear V and leave C unchanged.
- R7: Every ALU operation sets Z when its 16-bit result is zero and copies result bit 15 into N.
- R8: Opcode 6 (left shift) and opcode 7 (right logical shift) take the value in register rd_i, shift it by the value in register rs2_i and write the result back to rd_i. rs1_i is ignored for these opcodes. C receives the last bit shifted out.
- R9: A shift count of 0 leaves the value and C unchanged. A count of 16 gives zero, with C set to bit 0 (left) or bit 15 (right). A count above 16 gives zero with C cleared.
- R10: Source reads see the register values from before the edge. This holds even when the destination is also a source.
- R11: When ext_we_i is high and we_i is low, ext_data_i is written to register rd_i, with register 0 still discarding the write, and the flags are unchanged. When both are high, the ALU result is written and ext_data_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Decoded operation code (0..7) |
| rd_i | input | 3 | Destination index; first operand of shifts |
| rs1_i | input | 3 | First source index (three-operand form) |
| rs2_i | input | 3 | Second source index; shift count register |
| we_i | input | 1 | Execute the operation this cycle |
| ext_we_i | input | 1 | Write ext_data_i to rd_i |
| ext_data_i | input | 16 | Data from the memory stage |
| regs_o | output | 128 | Register file, register k in bits 16k+15..16k |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry / borrow flag |

## Verification
The bench targets shift counts of 0, 1, 15, 16, 17 and very large values. A shifter that wraps the count modulo 16 would return the unshifted value at count 16, and one that clears C at count 0 would break carry chains. It drives additions across the signed boundary and subtractions that borrow, where an inverted borrow or a misplaced overflow term shows up directly in C and V. It also writes to register 0, uses the same register as source and destination, and collides the load path with an ALU write. A design with a live register 0, a write-before-read hazard or the wrong priority would corrupt a register there.

// File: rtl/rex_pkg.sv
package rex_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_LSL = 3'd6,
    OP_LSR = 3'd7
  } rex_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } rex_flags_t;
endpackage

// File: rtl/rex_regfile.sv
module rex_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [IDX_W-1:0]           ra_idx_i,
  input  logic [IDX_W-1:0]           rb_idx_i,
  output logic [DATA_W-1:0]          ra_data_o,
  output logic [DATA_W-1:0]          rb_data_o,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_row
    if (g == 0) begin : g_zero
      assign regs_o[DATA_W-1:0] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                       q <= '0;
        else if (wr_en_i && wr_idx_i == IDX_W'(g))         q <= wr_data_i;
      end
      assign regs_o[g*DATA_W +: DATA_W] = q;
    end
  end

  assign ra_data_o = regs_o[ra_idx_i*DATA_W +: DATA_W];
  assign rb_data_o = regs_o[rb_idx_i*DATA_W +: DATA_W];
endmodule

// File: rtl/rex_alu.sv
module rex_alu import rex_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  rex_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] sum;
  logic [DATA_W:0] dif;

  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, (op_i == OP_ADC) & c_i};
    dif = {1'b0, a_i} - {1'b0, b_i};
    res_o = a_i;
    c_o   = c_i;
    v_o   = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADC: begin
        res_o = sum[MSB:0];
        c_o   = sum[DATA_W];
        v_o   = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
      end
      OP_SUB: begin
        res_o = dif[MSB:0];
        c_o   = dif[DATA_W];  // borrow
        v_o   = (a_i[MSB] != b_i[MSB]) && (dif[MSB] != a_i[MSB]);
      end
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/rex_shifter.sv
module rex_shifter #(
  parameter int DATA_W = 16,
  localparam int SH_W  = $clog2(DATA_W + 1)
) (
  input  logic              left_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);
  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(DATA_W);

  logic            over;
  logic [SH_W-1:0] amt;
  logic [DATA_W:0] ext_l;
  logic [DATA_W:0] ext_r;

  always_comb begin
    over  = cnt_i > LIMIT;
    amt   = cnt_i[SH_W-1:0];
    // one guard bit catches the last bit shifted out
    ext_l = {1'b0, a_i} << amt;
    ext_r = {a_i, 1'b0} >> amt;
    if (cnt_i == '0) begin
      res_o = a_i;
      c_o   = c_i;
    end else if (over) begin
      res_o = '0;
      c_o   = 1'b0;
    end else if (left_i) begin
      res_o = ext_l[DATA_W-1:0];
      c_o   = ext_l[DATA_W];
    end else begin
      res_o = ext_r[DATA_W:1];
      c_o   = ext_r[0];
    end
  end
endmodule

// File: rtl/rex_exec.sv
module rex_exec import rex_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2:0]                 op_i,
  input  logic [IDX_W-1:0]           rd_i,
  input  logic [IDX_W-1:0]           rs1_i,
  input  logic [IDX_W-1:0]           rs2_i,
  input  logic                       we_i,
  input  logic                       ext_we_i,
  input  logic [DATA_W-1:0]          ext_data_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       n_o,
  output logic                       z_o,
  output logic                       v_o,
  output logic                       c_o
);
  rex_op_e           op;
  logic              is_shift;
  logic              is_arith;
  logic [IDX_W-1:0]  ra_idx;
  logic [DATA_W-1:0] opa, opb;
  logic [DATA_W-1:0] alu_res, sh_res, res;
  logic              alu_c, alu_v, sh_c;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  rex_flags_t        flg_q, flg_d;

  assign op       = rex_op_e'(op_i);
  assign is_shift = (op == OP_LSL) || (op == OP_LSR);
  assign is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB);
  // two-operand form: first operand is the destination itself
  assign ra_idx   = is_shift ? rd_i : rs1_i;

  assign wr_en   = we_i | ext_we_i;
  assign wr_data = we_i ? res : ext_data_i;

  rex_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_idx_i  (ra_idx),
    .rb_idx_i  (rs2_i),
    .ra_data_o (opa),
    .rb_data_o (opb),
    .wr_en_i   (wr_en),
    .wr_idx_i  (rd_i),
    .wr_data_i (wr_data),
    .regs_o    (regs_o)
  );

  rex_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op),
    .a_i   (opa),
    .b_i   (opb),
    .c_i   (flg_q.c),
    .res_o (alu_res),
    .c_o   (alu_c),
    .v_o   (alu_v)
  );

  rex_shifter #(.DATA_W(DATA_W)) u_sh (
    .left_i (op == OP_LSL),
    .a_i    (opa),
    .cnt_i  (opb),
    .c_i    (flg_q.c),
    .res_o  (sh_res),
    .c_o    (sh_c)
  );

  always_comb begin
    res     = is_shift ? sh_res : alu_res;
    flg_d.n = res[DATA_W-1];
    flg_d.z = (res == '0);
    flg_d.v = is_arith & alu_v;
    flg_d.c = is_shift ? sh_c : alu_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flg_q <= '0;
    else if (we_i) flg_q <= flg_d;
  end

  assign n_o = flg_q.n;
  assign z_o = flg_q.z;
  assign v_o = flg_q.v;
  assign c_o = flg_q.c;
endmodule

// File: rtl/rex_exec_chk.sv
module rex_exec_chk #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [2:0]                 op_i,
  input logic [IDX_W-1:0]           rd_i,
  input logic [IDX_W-1:0]           rs2_i,
  input logic                       we_i,
  input logic                       ext_we_i,
  input logic [NUM_REGS*DATA_W-1:0] regs_o,
  input logic                       n_o,
  input logic                       z_o,
  input logic                       v_o,
  input logic                       c_o
);
  logic             we_q;
  logic [IDX_W-1:0] rd_q;
  logic [3:0]       flags;
  logic [DATA_W-1:0] dst_val;
  logic [DATA_W-1:0] cnt_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b0;
      rd_q <= '0;
    end else begin
      we_q <= we_i;
      rd_q <= rd_i;
    end
  end

  assign flags   = {n_o, z_o, v_o, c_o};
  assign dst_val = regs_o[rd_q*DATA_W +: DATA_W];
  assign cnt_val = regs_o[rs2_i*DATA_W +: DATA_W];

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !ext_we_i) |=> ($stable(regs_o) && $stable(flags)));

  // R2
  r0_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && rd_i == '0) |=> $stable(regs_o));

  // R2
  r0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o[DATA_W-1:0] == '0);

  // R7
  nz_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && rd_q != '0) |-> (z_o == (dst_val == '0) && n_o == dst_val[DATA_W-1]));

  // R6
  logic_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (op_i == 3'd3 || op_i == 3'd4 || op_i == 3'd5)) |=> (!v_o && c_o == $past(c_o)));

  // R9
  shift_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i[2:1] == 2'b11 && cnt_val == '0) |=> (c_o == $past(c_o) && !v_o));

  // R11
  ext_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_we_i && !we_i) |=> $stable(flags));
endmodule

bind rex_exec rex_exec_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .rd_i     (rd_i),
  .rs2_i    (rs2_i),
  .we_i     (we_i),
  .ext_we_i (ext_we_i),
  .regs_o   (regs_o),
  .n_o      (n_o),
  .z_o      (z_o),
  .v_o      (v_o),
  .c_o      (c_o)
);

// File: tb/rex_exec_bench.sv
module rex_exec_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   op_i = '0;
  logic [2:0]   rd_i = '0, rs1_i = '0, rs2_i = '0;
  logic         we_i = 1'b0, ext_we_i = 1'b0;
  logic [15:0]  ext_data_i = '0;
  logic [127:0] regs_o;
  logic         n_o, z_o, v_o, c_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m [8];
  logic        mn, mz, mv, mc;

  always #5 clk_i = ~clk_i;

  rex_exec u_rex_exec (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .rd_i(rd_i), .rs1_i(rs1_i),
    .rs2_i(rs2_i), .we_i(we_i), .ext_we_i(ext_we_i), .ext_data_i(ext_data_i),
    .regs_o(regs_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
  );

  function automatic logic [127:0] flat();
    logic [127:0] f;
    for (int k = 0; k < 8; k++) f[k*16 +: 16] = m[k];
    return f;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (regs_o !== flat()) begin
      fails++;
      $display("FAIL %s regs actual=%h expected=%h", tag, regs_o, flat());
    end
    checks++;
    if ({n_o, z_o, v_o, c_o} !== {mn, mz, mv, mc}) begin
      fails++;
      $display("FAIL %s flags nzvc actual=%b expected=%b", tag,
               {n_o, z_o, v_o, c_o}, {mn, mz, mv, mc});
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [15:0] a, b,
                                input logic cin, output logic [15:0] r,
                                output logic c, v);
    logic [16:0] s;
    c = cin; v = 1'b0; r = a;
    case (op)
      3'd0, 3'd1: begin
        s = 17'(a) + 17'(b) + 17'((op == 3'd1) ? cin : 1'b0);
        r = s[15:0]; c = s[16];
        v = (a[15] == b[15]) && (r[15] != a[15]);
      end
      3'd2: begin
        r = a - b; c = (a < b);
        v = (a[15] != b[15]) && (r[15] != a[15]);
      end
      3'd3: r = a & b;
      3'd4: r = a | b;
      3'd5: r = a ^ b;
      default: begin
        if (b == 0) begin r = a; c = cin; end
        else if (b > 16) begin r = '0; c = 1'b0; end
        else if (op == 3'd6) begin r = a << b; c = a[16 - b]; end
        else begin r = a >> b; c = a[b - 1]; end
      end
    endcase
  endfunction

  // called at a negedge, returns at a negedge
  task automatic run_op(input logic [2:0] op, input int rd, rs1, rs2, input string tag);
    logic [15:0] a, r;
    logic c, v;
    a = (op >= 3'd6) ? m[rd] : m[rs1];
    model(op, a, m[rs2], mc, r, c, v);
    op_i = op; rd_i = 3'(rd); rs1_i = 3'(rs1); rs2_i = 3'(rs2); we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (rd != 0) m[rd] = r;
    mn = r[15]; mz = (r == 0); mv = v; mc = c;
    compare(tag);
  endtask

  task automatic load(input int rd, input logic [15:0] val, input string tag);
    rd_i = 3'(rd); ext_data_i = val; ext_we_i = 1'b1;
    @(negedge clk_i);
    ext_we_i = 1'b0;
    if (rd != 0) m[rd] = val;
    compare(tag);
  endtask

  function automatic string tag_of(input logic [2:0] op, input int rd);
    if (rd == 0) return "R2";
    if (op <= 3'd2) return "R4";
    if (op <= 3'd5) return "R6";
    return "R8";
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 8; k++) m[k] = '0;
    {mn, mz, mv, mc} = '0;
    repeat (3) @(negedge clk_i);
    compare("R1");  // reset state
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    load(1, 16'h7FFF, "R11");
    load(2, 16'h0001, "R11");
    load(0, 16'hBEEF, "R2");
    run_op(3'd0, 3, 1, 2, "R5");   // 0x7FFF+1: signed overflow
    run_op(3'd2, 4, 2, 1, "R4");   // 1-0x7FFF: borrow
    run_op(3'd1, 5, 2, 2, "R4");   // 1+1+C
    load(6, 16'hFFFF, "R11");
    run_op(3'd0, 7, 6, 2, "R7");   // 0xFFFF+1 = 0, carry
    run_op(3'd2, 7, 3, 3, "R7");   // self minus self
    run_op(3'd0, 0, 1, 2, "R2");   // flags only
    run_op(3'd5, 0, 6, 6, "R2");
    run_op(3'd0, 1, 1, 1, "R10");  // dest is also both sources
    run_op(3'd3, 5, 6, 1, "R6");
    load(7, 16'h8001, "R11");

    // shift counts at the edges
    foreach (m[i]) ;
    begin
      logic [15:0] cnts [7] = '{16'd0, 16'd1, 16'd15, 16'd16, 16'd17, 16'h8000, 16'd3};
      for (int i = 0; i < 7; i++) begin
        load(2, cnts[i], "R9");
        load(4, 16'hA5C3, "R9");
        run_op(3'd6, 4, 5, 2, "R9");
        load(4, 16'hA5C3, "R9");
        run_op(3'd7, 4, 5, 2, "R9");
      end
    end

    // idle cycle after setting carry: nothing moves
    run_op(3'd0, 3, 6, 6, "R4");
    op_i = 3'd0; rd_i = 3'd3; rs1_i = 3'd1; rs2_i = 3'd1; ext_data_i = 16'h1234;
    @(negedge clk_i);
    compare("R3");

    // ALU write collides with load path: ALU wins
    begin
      logic [15:0] r;
      logic c, v;
      model(3'd4, m[6], m[7], mc, r, c, v);
      op_i = 3'd4; rd_i = 3'd3; rs1_i = 3'd6; rs2_i = 3'd7;
      ext_data_i = 16'h5A5A; ext_we_i = 1'b1; we_i = 1'b1;
      @(negedge clk_i);
      we_i = 1'b0; ext_we_i = 1'b0;
      m[3] = r; mn = r[15]; mz = (r == 0); mv = v; mc = c;
      compare("R11");
    end

    for (int it = 0; it < 400; it++) begin
      int sel, rd, rs1, rs2;
      logic [2:0] op;
      sel = $urandom_range(0, 9);
      if (sel < 3) begin
        rd = $urandom_range(0, 7);
        if (sel == 0) load(rd, 16'($urandom_range(0, 20)), "R11");
        else load(rd, 16'($urandom), "R11");
      end else begin
        op = 3'($urandom_range(0, 7));
        rd = $urandom_range(0, 7);
        rs1 = $urandom_range(0, 7);
        rs2 = $urandom_range(0, 7);
        run_op(op, rd, rs1, rs2, tag_of(op, rd));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule